// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block walks a ring of receive descriptors in memory on behalf of a frame receiver. Software loads a ring base address and then sets a receive-request bit. The engine reads the first 32-bit word of the descriptor at its current pointer over a simple read port and checks the ownership flag in bit 31. A set flag means the buffer is ready. The engine then grants the frame receiver permission to fill that descriptor's buffer. When the receiver reports that the frame is done, the engine writes the word back with ownership returned to software and a receive status code placed in the low bits.

After each write-back the pointer advances by one descriptor slot. If the descriptor's end-of-ring flag (bit 30) was set, the pointer goes back to the ring base instead. A descriptor that software still owns stops reception: the engine clears the receive-request bit and goes idle. The pointer stays on that slot, so that setting the request bit again resumes at the same descriptor. A done pulse that arrives when no buffer is granted is discarded, and a sticky error flag records it.

Top module: `rx_desc_ring`

## Requirements
- R1: While reset is held and just after it, `rx_req`, `mem_rd_req`, `mem_wr_req`, `xfer_grant` and `err_stray` are all 0.
- R2: A one-cycle pulse on `sw_req_set` sets `rx_req` to 1. The engine then issues a read with `mem_rd_req` at the current descriptor address, and no read is issued while `rx_req` is 0.
- R3: When the fetched word has bit 31 = 1, `xfer_grant` rises in the next cycle with `xfer_addr` equal to the fetched address. It stays high and stable until `frame_done` is seen.
- R4: When the fetched word has bit 31 = 0, `rx_req` returns to 0 in the next cycle. No grant is given and no write-back is issued.
- R5: After `frame_done` during a grant, one write is issued to the descriptor address. Its data has bit 31 = 0, bit 30 equal to the fetched bit 30, and bits 29:0 equal to `frame_status` as sampled with `frame_done`.
- R6: After a write-back is acknowledged for a descriptor whose bit 30 was 0, the next fetch address is the previous one plus DESC_BYTES (16).
- R7: After a write-back is acknowledged for a descriptor whose bit 30 was 1, the next fetch address is the ring base.
- R8: After a halt, a new `sw_req_set` pulse re-fetches the same descriptor address at which the engine stopped.
- R9: A `frame_done` while `xfer_grant` is 0 causes no write-back and sets `err_stray`. The flag remains 1 until reset.
- R10: `cfg_base_load` while `rx_req` is 0 makes the next fetch address equal to `cfg_base`.
- R11: At most one of `mem_rd_req`, `mem_wr_req` and `xfer_grant` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_base_load | input | 1 | Load base; also resets the pointer when stopped |
| sw_req_set | input | 1 | Software pulse that sets the receive-request bit |
| rx_req | output | 1 | Receive-request bit state |
| mem_rd_req | output | 1 | Descriptor read request, held until valid |
| mem_rd_addr | output | ADDR_W | Descriptor read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Descriptor word 0 |
| mem_wr_req | output | 1 | Write-back request, held until acknowledged |
| mem_wr_addr | output | ADDR_W | Write-back address |
| mem_wr_data | output | DATA_W | Write-back word |
| mem_wr_ack | input | 1 | Write accepted |
| xfer_grant | output | 1 | Frame receiver may fill the buffer |
| xfer_addr | output | ADDR_W | Descriptor address for the granted buffer |
| frame_done | input | 1 | Frame receiver finished a frame |
| frame_status | input | DATA_W-2 | Receive status code for write-back |
| err_stray | output | 1 | Sticky flag for a done pulse with no grant |

## Verification
A wrong pointer shows up at the read port as the wrong address, at the first fetch after the faulty advance or wrap. A wrong ownership decision shows up at `xfer_grant` or `rx_req` one cycle after the read completes. A corrupted latched flag or status shows up at the write-back data in the cycle the write is requested. A state machine stuck in the wrong state shows up as a missing read, grant or write within a few cycles, and the bench bounds every wait for these.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_GRANT = 2'd2,
    ST_WB    = 2'd3
  } rxd_state_e;
endpackage

// File: rtl/rxd_req.sv
module rxd_req (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic halt_i,
  output logic req_o
);
  logic req_q, req_d, req_en;

  always_comb begin
    req_en = set_i | halt_i;
    req_d  = halt_i ? 1'b0 : 1'b1;   // halt has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_en) req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/rxd_ptr.sv
module rxd_ptr #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_load_i,
  input  logic              idle_i,
  input  logic              adv_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] cur_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] base_q, cur_q, cur_d;
  logic              cur_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           base_q <= '0;
    else if (base_load_i) base_q <= base_i;
  end

  always_comb begin
    cur_en = 1'b0;
    cur_d  = cur_q;
    if (base_load_i && idle_i) begin
      cur_en = 1'b1;
      cur_d  = base_i;
    end else if (adv_i) begin
      cur_en = 1'b1;
      cur_d  = wrap_i ? base_q : (cur_q + STRIDE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
  import rxd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              wr_ack_i,
  input  logic              done_i,
  input  logic [DATA_W-3:0] status_i,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              grant_o,
  output logic              halt_o,
  output logic              adv_o,
  output logic              wrap_o,
  output logic              idle_o,
  output logic              err_o
);
  localparam int OWN_BIT  = DATA_W - 1;
  localparam int LAST_BIT = DATA_W - 2;
  localparam int STAT_W   = DATA_W - 2;

  rxd_state_e        state_q, state_d;
  logic              last_q, last_en;
  logic [STAT_W-1:0] stat_q;
  logic              stat_en;
  logic              err_q, err_en;

  always_comb begin
    state_d = state_q;
    halt_o  = 1'b0;
    adv_o   = 1'b0;
    last_en = 1'b0;
    stat_en = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_FETCH;
      ST_FETCH: if (rd_valid_i) begin
        if (rd_data_i[OWN_BIT]) begin
          last_en = 1'b1;
          state_d = ST_GRANT;
        end else begin
          halt_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_GRANT: if (done_i) begin
        stat_en = 1'b1;
        state_d = ST_WB;
      end
      ST_WB: if (wr_ack_i) begin
        adv_o   = 1'b1;
        state_d = ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b0;
    else if (last_en) last_q <= rd_data_i[LAST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= status_i;
  end

  // A done pulse outside the grant window is dropped and remembered.
  assign err_en = done_i && (state_q != ST_GRANT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= 1'b1;
  end

  assign rd_req_o  = (state_q == ST_FETCH);
  assign grant_o   = (state_q == ST_GRANT);
  assign wr_req_o  = (state_q == ST_WB);
  assign wr_data_o = {1'b0, last_q, stat_q};
  assign wrap_o    = last_q;
  assign idle_o    = (state_q == ST_IDLE);
  assign err_o     = err_q;
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_base_load,
  input  logic              sw_req_set,
  output logic              rx_req,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              xfer_grant,
  output logic [ADDR_W-1:0] xfer_addr,
  input  logic              frame_done,
  input  logic [DATA_W-3:0] frame_status,
  output logic              err_stray
);
  // Reset asserts asynchronously and is released on a clock edge.
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic              halt, adv, wrap, idle;
  logic [ADDR_W-1:0] cur_addr;

  rxd_req u_req (
    .clk   (clk),
    .rst_n (rst_s2),
    .set_i (sw_req_set),
    .halt_i(halt),
    .req_o (rx_req)
  );

  rxd_ptr #(
    .ADDR_W    (ADDR_W),
    .DESC_BYTES(DESC_BYTES)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_s2),
    .base_i     (cfg_base),
    .base_load_i(cfg_base_load),
    .idle_i     (~rx_req & idle),
    .adv_i      (adv),
    .wrap_i     (wrap),
    .cur_o      (cur_addr)
  );

  rxd_fsm #(
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s2),
    .req_i     (rx_req),
    .rd_valid_i(mem_rd_valid),
    .rd_data_i (mem_rd_data),
    .wr_ack_i  (mem_wr_ack),
    .done_i    (frame_done),
    .status_i  (frame_status),
    .rd_req_o  (mem_rd_req),
    .wr_req_o  (mem_wr_req),
    .wr_data_o (mem_wr_data),
    .grant_o   (xfer_grant),
    .halt_o    (halt),
    .adv_o     (adv),
    .wrap_o    (wrap),
    .idle_o    (idle),
    .err_o     (err_stray)
  );

  assign mem_rd_addr = cur_addr;
  assign mem_wr_addr = cur_addr;
  assign xfer_addr   = cur_addr;
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_req,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_valid,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic              mem_wr_req,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              xfer_grant,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              frame_done,
  input logic              err_stray
);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, mem_wr_req, xfer_grant}));

  p_read_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> rx_req);

  p_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && mem_rd_data[DATA_W-1])
      |=> (xfer_grant && xfer_addr == $past(mem_rd_addr)));

  p_grant_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_grant && !frame_done) |=> (xfer_grant && $stable(xfer_addr)));

  p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && !mem_rd_data[DATA_W-1])
      |=> (!rx_req && !xfer_grant && !mem_wr_req));

  p_wb_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !mem_wr_data[DATA_W-1]);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_stray |=> err_stray);

  p_stray_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !xfer_grant) |=> err_stray);
endmodule

bind rx_desc_ring rxd_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_rxd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_req      (rx_req),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_data (mem_rd_data),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_data (mem_wr_data),
  .xfer_grant  (xfer_grant),
  .xfer_addr   (xfer_addr),
  .frame_done  (frame_done),
  .err_stray   (err_stray)
);

// File: tb/test_rx_desc_ring.sv
module test_rx_desc_ring;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic          cfg_base_load = 1'b0;
  logic          sw_req_set = 1'b0;
  logic          rx_req;
  logic          mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rd_valid = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic          mem_wr_req;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_wr_ack = 1'b0;
  logic          xfer_grant;
  logic [AW-1:0] xfer_addr;
  logic          frame_done = 1'b0;
  logic [DW-3:0] frame_status = '0;
  logic          err_stray;

  always #5 clk = ~clk;

  rx_desc_ring i_rx_desc_ring (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_base_load(cfg_base_load),
    .sw_req_set(sw_req_set), .rx_req(rx_req), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .xfer_grant(xfer_grant), .xfer_addr(xfer_addr),
    .frame_done(frame_done), .frame_status(frame_status), .err_stray(err_stray)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] mem [16];
  int          rd_cnt = 0, wr_cnt = 0, grant_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Memory responder: answers a held request one cycle later.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req && !mem_rd_valid) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem[mem_rd_addr[7:4]];
        last_rd_addr = mem_rd_addr;
        rd_cnt++;
      end else begin
        mem_rd_valid = 1'b0;
      end
      if (mem_wr_req && !mem_wr_ack) begin
        mem_wr_ack   = 1'b1;
        mem[mem_wr_addr[7:4]] = mem_wr_data;
        last_wr_addr = mem_wr_addr;
        last_wr_data = mem_wr_data;
        wr_cnt++;
      end else begin
        mem_wr_ack = 1'b0;
      end
      if (xfer_grant) grant_cnt++;
    end
  end

  task automatic wait_read(input logic [31:0] exp_addr, input string req);
    int start = rd_cnt;
    for (int i = 0; i < 40 && rd_cnt == start; i++) @(negedge clk);
    check(rd_cnt > start && last_rd_addr == exp_addr, req, last_rd_addr, exp_addr);
  endtask

  task automatic frame(input logic [29:0] st, input logic [31:0] exp_addr,
                       input logic [31:0] exp_data, input string req);
    int start;
    @(negedge clk);
    check(xfer_grant === 1'b1 && xfer_addr == exp_addr, "R3", xfer_addr, exp_addr);
    repeat (3) @(negedge clk);
    check(xfer_grant === 1'b1 && xfer_addr == exp_addr, "R3 hold", xfer_addr, exp_addr);
    start = wr_cnt;
    frame_status = st;
    frame_done   = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    for (int i = 0; i < 20 && wr_cnt == start; i++) @(negedge clk);
    check(wr_cnt == start + 1 && last_wr_addr == exp_addr, {req, " addr"},
          last_wr_addr, exp_addr);
    check(last_wr_data == exp_data, {req, " data"}, last_wr_data, exp_data);
  endtask

  task automatic arm();
    @(negedge clk);
    sw_req_set = 1'b1;
    @(negedge clk);
    sw_req_set = 1'b0;
  endtask

  task automatic t_reset();
    check(rx_req == 0 && mem_rd_req == 0 && mem_wr_req == 0 &&
          xfer_grant == 0 && err_stray == 0, "R1",
          {27'd0, rx_req, mem_rd_req, mem_wr_req, xfer_grant, err_stray}, 32'd0);
  endtask

  task automatic t_ring_walk();
    int g0;
    mem[0] = 32'h8000_0000;
    mem[1] = 32'h8000_0000;
    mem[2] = 32'hC000_0000;     // last in ring
    @(negedge clk);
    cfg_base = BASE; cfg_base_load = 1'b1;
    @(negedge clk);
    cfg_base_load = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_cnt == 0, "R2 no read while stopped", rd_cnt, 0);
    arm();
    check(rx_req === 1'b1, "R2 req set", rx_req, 1);
    wait_read(BASE, "R10 first fetch at base");
    frame(30'h155, BASE, 32'h0000_0155, "R5 wb desc0");
    wait_read(BASE + 16, "R6 step");
    frame(30'h2AA, BASE + 16, 32'h0000_02AA, "R5 wb desc1");
    wait_read(BASE + 32, "R6 step 2");
    frame(30'h3FFF_FFFF, BASE + 32, 32'h7FFF_FFFF, "R5 wb last keeps bit30");
    g0 = grant_cnt;
    wait_read(BASE, "R7 wrap");
    repeat (3) @(negedge clk);
    check(rx_req === 1'b0, "R4 halt clears req", rx_req, 0);
    check(grant_cnt == g0 && !xfer_grant, "R4 no grant", grant_cnt, g0);
  endtask

  task automatic t_stray();
    int w0 = wr_cnt;
    @(negedge clk);
    frame_done = 1'b1; frame_status = 30'h1234;
    @(negedge clk);
    frame_done = 1'b0;
    repeat (4) @(negedge clk);
    check(err_stray === 1'b1, "R9 flag", err_stray, 1);
    check(wr_cnt == w0 && !mem_wr_req, "R9 no write", wr_cnt, w0);
    repeat (5) @(negedge clk);
    check(err_stray === 1'b1, "R9 sticky", err_stray, 1);
  endtask

  task automatic t_restart();
    int g0;
    mem[0] = 32'h8000_0000;     // desc1 still owned by software
    arm();
    wait_read(BASE, "R8 refetch halted slot");
    frame(30'h0AB, BASE, 32'h0000_00AB, "R5 wb after restart");
    wait_read(BASE + 16, "R6 step to owned slot");
    g0 = grant_cnt;
    repeat (3) @(negedge clk);
    check(rx_req === 1'b0 && grant_cnt == g0, "R4 halt mid-ring", rx_req, 0);
    mem[1] = 32'h8000_0000;
    arm();
    wait_read(BASE + 16, "R8 resume mid-ring");
    frame(30'h00F, BASE + 16, 32'h0000_000F, "R5 wb resumed");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ring_walk();
    t_stray();
    t_restart();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule